// File: doc/BRIEF.md
# Bounded Indexed Address Check Unit

This unit holds a small file of numbered register triples. Each triple has a base address, an index and a bound. The unit issues register-relative indexed loads and stores on a simple synchronous memory port. For every access it adds the index to the base to get the effective address. Before any request goes out, it checks the index against the bound of the same triple. If the index is larger than the bound, no request is issued and a one-cycle fault pulse names the triple that failed.

A third operation, the reference load, brings a whole bounded pointer in from memory. It reads two consecutive words starting at the effective address of the source triple. The lower word becomes the destination base and the upper word becomes the destination bound. The unit holds `busy` high until both transactions have completed.

A setup port writes any register of any triple, and a peek port reads a whole triple combinationally. Software or a test environment uses these to seed and observe the state.

Top module: `bic_unit`

## Requirements
- R1: After reset every base, index and bound register reads zero, and `busy`, `mem_req` and `fault` are low.
- R2: With `set_we` high, the register chosen by `set_sel` in triple `set_idx` takes `set_data` at the clock edge. The `set_sel` encoding is 0 for base, 1 for index and 2 for bound; value 3 writes nothing. The peek port shows the triple selected by `pk_idx`.
- R3: An indexed load (`op_kind` 0) that passes its check issues one read at base(src)+index(src) and writes the returned word into base(dst). No other register changes.
- R4: An indexed store (`op_kind` 1) that passes its check issues one write of base(src) to base(dst)+index(dst). It completes on `mem_rvalid` and changes no register.
- R5: The check passes when index ≤ bound, compared as unsigned values of the register width. An index equal to the bound is allowed. An index with its top bit set never passes against a smaller bound.
- R6: When the check fails, no memory request is issued and no register changes. `fault` is high for the single cycle after acceptance, with `fault_idx` naming the checked triple: src for loads and reference loads, dst for stores. `busy` stays low.
- R7: A reference load (`op_kind` 2) is checked against the source triple. It reads the effective address and then the effective address plus one. The first word goes into base(dst) and the second into bound(dst). `busy` stays high until the second response arrives.
- R8: An operation is accepted only while `busy` is low. `op_valid` during `busy` has no effect, and `op_kind` 3 is ignored.
- R9: Every `mem_req` is a single-cycle pulse with address, write enable and write data valid in that cycle. No new request follows until a response has arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| set_we | input | 1 | Setup write strobe |
| set_sel | input | 2 | Register select: 0 base, 1 index, 2 bound |
| set_idx | input | IW | Triple number for setup write |
| set_data | input | W | Setup write data |
| pk_idx | input | IW | Triple number to peek |
| pk_addr | output | W | Base register of peeked triple |
| pk_index | output | W | Index register of peeked triple |
| pk_bound | output | W | Bound register of peeked triple |
| op_valid | input | 1 | Operation request |
| op_kind | input | 2 | 0 load, 1 store, 2 reference load, 3 ignored |
| op_dst | input | IW | Destination triple |
| op_src | input | IW | Source triple |
| busy | output | 1 | Operation in progress |
| mem_req | output | 1 | Memory request pulse |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | W | Request address |
| mem_wdata | output | W | Write data |
| mem_rvalid | input | 1 | Memory response |
| mem_rdata | input | W | Read data |
| fault | output | 1 | Bounds exception pulse |
| fault_idx | output | IW | Triple that failed the check |

## Verification
The bench drives an index exactly equal to its bound. A design that used greater-or-equal would fault there instead of issuing the read. It also drives an index with the top bit set against a mid-range bound, which a signed comparator would wrongly let through. Stores are checked against the destination triple while loads are checked against the source, so a swapped selector would fault on the wrong triple or issue an out-of-range write. The reference load checks the second address, the bound register written from the second word, and the busy window. A request sent during `busy` checks that no second transaction starts.

// File: rtl/bic_pkg.sv
package bic_pkg;
  localparam logic [1:0] OP_LOAD  = 2'd0;
  localparam logic [1:0] OP_STORE = 2'd1;
  localparam logic [1:0] OP_REF   = 2'd2;
  localparam logic [1:0] OP_RSVD  = 2'd3;

  localparam logic [1:0] SEL_ADDR  = 2'd0;
  localparam logic [1:0] SEL_INDEX = 2'd1;
  localparam logic [1:0] SEL_BOUND = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_REQ     = 3'd1,
    ST_WAIT    = 3'd2,
    ST_REQ_HI  = 3'd3,
    ST_WAIT_HI = 3'd4
  } bic_state_e;
endpackage

// File: rtl/bic_check.sv
// Effective address and strict unsigned bound test for one triple.
module bic_check #(
  parameter int W = 32
) (
  input  logic [W-1:0] base,
  input  logic [W-1:0] index,
  input  logic [W-1:0] bound,
  output logic [W-1:0] ea,
  output logic         viol
);
  always_comb begin
    ea   = base + index;
    viol = (index > bound);
  end
endmodule

// File: rtl/bic_regfile.sv
// Triple register file: one setup write port, one writeback port for
// base/bound, two access read ports and a peek read port.
module bic_regfile #(
  parameter int W  = 32,
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          set_we,
  input  logic [1:0]    set_sel,
  input  logic [IW-1:0] set_idx,
  input  logic [W-1:0]  set_data,
  input  logic          wba_en,
  input  logic          wbb_en,
  input  logic [IW-1:0] wb_idx,
  input  logic [W-1:0]  wb_data,
  input  logic [IW-1:0] ra_idx,
  output logic [W-1:0]  ra_a,
  output logic [W-1:0]  ra_i,
  output logic [W-1:0]  ra_b,
  input  logic [IW-1:0] rb_idx,
  output logic [W-1:0]  rb_a,
  input  logic [IW-1:0] pk_idx,
  output logic [W-1:0]  pk_a,
  output logic [W-1:0]  pk_i,
  output logic [W-1:0]  pk_b
);
  import bic_pkg::*;

  logic [W-1:0] a_q [N];
  logic [W-1:0] i_q [N];
  logic [W-1:0] b_q [N];

  for (genvar g = 0; g < N; g++) begin : g_ent
    logic         a_en, i_en, b_en;
    logic [W-1:0] a_d, b_d;
    logic         hit_set, hit_wb;

    // Writeback from memory wins over a setup write in the same cycle.
    always_comb begin
      hit_set = set_we && (set_idx == IW'(g));
      hit_wb  = (wb_idx == IW'(g));
      a_en    = (hit_wb && wba_en) || (hit_set && set_sel == SEL_ADDR);
      i_en    = hit_set && (set_sel == SEL_INDEX);
      b_en    = (hit_wb && wbb_en) || (hit_set && set_sel == SEL_BOUND);
      a_d     = (hit_wb && wba_en) ? wb_data : set_data;
      b_d     = (hit_wb && wbb_en) ? wb_data : set_data;
    end

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
        a_q[g] <= '0;
        i_q[g] <= '0;
        b_q[g] <= '0;
      end else begin
        if (a_en) a_q[g] <= a_d;
        if (i_en) i_q[g] <= set_data;
        if (b_en) b_q[g] <= b_d;
      end
    end
  end

  always_comb begin
    ra_a = a_q[ra_idx];
    ra_i = i_q[ra_idx];
    ra_b = b_q[ra_idx];
    rb_a = a_q[rb_idx];
    pk_a = a_q[pk_idx];
    pk_i = i_q[pk_idx];
    pk_b = b_q[pk_idx];
  end
endmodule

// File: rtl/bic_unit.sv
module bic_unit #(
  parameter  int W  = 32,
  parameter  int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_we,
  input  logic [1:0]    set_sel,
  input  logic [IW-1:0] set_idx,
  input  logic [W-1:0]  set_data,
  input  logic [IW-1:0] pk_idx,
  output logic [W-1:0]  pk_addr,
  output logic [W-1:0]  pk_index,
  output logic [W-1:0]  pk_bound,
  input  logic          op_valid,
  input  logic [1:0]    op_kind,
  input  logic [IW-1:0] op_dst,
  input  logic [IW-1:0] op_src,
  output logic          busy,
  output logic          mem_req,
  output logic          mem_we,
  output logic [W-1:0]  mem_addr,
  output logic [W-1:0]  mem_wdata,
  input  logic          mem_rvalid,
  input  logic [W-1:0]  mem_rdata,
  output logic          fault,
  output logic [IW-1:0] fault_idx
);
  import bic_pkg::*;

  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rs_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  bic_state_e    st_q, st_d;
  logic [W-1:0]  ea_q, ea_d, wd_q, wd_d;
  logic [IW-1:0] dst_q, dst_d, fidx_q, fidx_d;
  logic          we_q, we_d, ref_q, ref_d, flt_q, flt_d;

  logic [IW-1:0] chk_idx;
  logic [W-1:0]  ra_a, ra_i, ra_b, rb_a, ea;
  logic          viol, accept, wba_en, wbb_en;

  // Stores are checked against the destination triple, everything else
  // against the source triple.
  assign chk_idx = (op_kind == OP_STORE) ? op_dst : op_src;
  assign accept  = (st_q == ST_IDLE) && op_valid && (op_kind != OP_RSVD);

  bic_regfile #(.W(W), .N(N), .IW(IW)) u_rf (
    .clk(clk), .rst_ni(rst_ni),
    .set_we(set_we), .set_sel(set_sel), .set_idx(set_idx), .set_data(set_data),
    .wba_en(wba_en), .wbb_en(wbb_en), .wb_idx(dst_q), .wb_data(mem_rdata),
    .ra_idx(chk_idx), .ra_a(ra_a), .ra_i(ra_i), .ra_b(ra_b),
    .rb_idx(op_src), .rb_a(rb_a),
    .pk_idx(pk_idx), .pk_a(pk_addr), .pk_i(pk_index), .pk_b(pk_bound)
  );

  bic_check #(.W(W)) u_chk (
    .base(ra_a), .index(ra_i), .bound(ra_b), .ea(ea), .viol(viol)
  );

  always_comb begin
    st_d   = st_q;
    ea_d   = ea_q;
    wd_d   = wd_q;
    dst_d  = dst_q;
    we_d   = we_q;
    ref_d  = ref_q;
    fidx_d = fidx_q;
    flt_d  = 1'b0;
    wba_en = 1'b0;
    wbb_en = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          if (viol) begin
            flt_d  = 1'b1;
            fidx_d = chk_idx;
          end else begin
            st_d  = ST_REQ;
            ea_d  = ea;
            wd_d  = rb_a;
            dst_d = op_dst;
            we_d  = (op_kind == OP_STORE);
            ref_d = (op_kind == OP_REF);
          end
        end
      end
      ST_REQ:    st_d = ST_WAIT;
      ST_WAIT: begin
        if (mem_rvalid) begin
          if (we_q) begin
            st_d = ST_IDLE;
          end else begin
            wba_en = 1'b1;
            if (ref_q) begin
              ea_d = ea_q + W'(1);
              st_d = ST_REQ_HI;
            end else begin
              st_d = ST_IDLE;
            end
          end
        end
      end
      ST_REQ_HI: st_d = ST_WAIT_HI;
      ST_WAIT_HI: begin
        if (mem_rvalid) begin
          wbb_en = 1'b1;
          st_d   = ST_IDLE;
        end
      end
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      ea_q   <= '0;
      wd_q   <= '0;
      dst_q  <= '0;
      we_q   <= 1'b0;
      ref_q  <= 1'b0;
      flt_q  <= 1'b0;
      fidx_q <= '0;
    end else begin
      st_q   <= st_d;
      ea_q   <= ea_d;
      wd_q   <= wd_d;
      dst_q  <= dst_d;
      we_q   <= we_d;
      ref_q  <= ref_d;
      flt_q  <= flt_d;
      fidx_q <= fidx_d;
    end
  end

  assign busy      = (st_q != ST_IDLE);
  assign mem_req   = (st_q == ST_REQ) || (st_q == ST_REQ_HI);
  assign mem_we    = mem_req && we_q;
  assign mem_addr  = ea_q;
  assign mem_wdata = wd_q;
  assign fault     = flt_q;
  assign fault_idx = fidx_q;
endmodule

// File: rtl/bic_unit_chk.sv
module bic_unit_chk (
  input logic clk,
  input logic rst_n,
  input logic mem_req,
  input logic mem_we,
  input logic busy,
  input logic fault
);
  // R6: a failed check never produces a memory request
  a_r6_no_req_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !mem_req);
  // R6: a faulting operation never enters the busy window
  a_r6_fault_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !busy);
  // R9: requests are single-cycle pulses
  a_r9_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  // R8: a request only exists inside an accepted operation
  a_r8_req_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);
  // R9: write enable is only meaningful with a request
  a_r9_we_with_req: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_req);
endmodule

bind bic_unit bic_unit_chk u_bic_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
  .busy(busy), .fault(fault)
);

// File: tb/bic_unit_tb.sv
`timescale 1ns/1ps
module bic_unit_tb;
  localparam int W  = 32;
  localparam int N  = 4;
  localparam int IW = 2;

  typedef struct {
    bit          is_fault;
    logic [W-1:0] addr;
    bit          we;
    logic [W-1:0] wdata;
    int          idx;
    string       tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic set_we = 1'b0;
  logic [1:0] set_sel = '0;
  logic [IW-1:0] set_idx = '0, pk_idx = '0, op_dst = '0, op_src = '0;
  logic [W-1:0] set_data = '0;
  logic [W-1:0] pk_addr, pk_index, pk_bound, mem_addr, mem_wdata;
  logic op_valid = 1'b0;
  logic [1:0] op_kind = '0;
  logic busy, mem_req, mem_we, fault;
  logic mem_rvalid = 1'b0;
  logic [W-1:0] mem_rdata = '0;
  logic [IW-1:0] fault_idx;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  exp_t q[$];

  always #2.5 clk = ~clk;

  bic_unit #(.W(W), .N(N)) u_dut (.*);

  function automatic logic [W-1:0] mval(logic [W-1:0] a);
    return a * 32'd3 + 32'h1000_0000;
  endfunction

  // memory model: answers every request in the following cycle
  always @(posedge clk) begin
    mem_rvalid <= mem_req;
    mem_rdata  <= mval(mem_addr);
  end

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: scoreboard of requests and faults
  always @(negedge clk) begin
    if (rst_n && (mem_req || fault)) begin
      if (q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R8: unexpected event req=%0b fault=%0b addr %h, expected none",
                 mem_req, fault, mem_addr);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (e.is_fault) begin
          check({e.tag, " fault"}, {31'd0, fault}, 32'd1);
          check({e.tag, " fault_idx"}, W'(fault_idx), W'(e.idx));
          check({e.tag, " no req"}, {31'd0, mem_req}, 32'd0);
        end else begin
          check({e.tag, " req"}, {31'd0, mem_req}, 32'd1);
          check({e.tag, " addr"}, mem_addr, e.addr);
          check({e.tag, " we"}, {31'd0, mem_we}, {31'd0, e.we});
          if (e.we) check({e.tag, " wdata"}, mem_wdata, e.wdata);
        end
      end
    end
  end

  task automatic exp_req(logic [W-1:0] a, bit we, logic [W-1:0] wd, string tag);
    exp_t e;
    e.is_fault = 0; e.addr = a; e.we = we; e.wdata = wd; e.idx = 0; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic exp_fault(int idx, string tag);
    exp_t e;
    e.is_fault = 1; e.addr = '0; e.we = 0; e.wdata = '0; e.idx = idx; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic setreg(int t, logic [1:0] sel, logic [W-1:0] d);
    @(negedge clk);
    set_we = 1; set_idx = IW'(t); set_sel = sel; set_data = d;
    @(negedge clk);
    set_we = 0;
  endtask

  task automatic peek(int t, string tag, logic [W-1:0] ea, logic [W-1:0] ei,
                      logic [W-1:0] eb);
    pk_idx = IW'(t);
    #1;
    check({tag, " base"}, pk_addr, ea);
    check({tag, " index"}, pk_index, ei);
    check({tag, " bound"}, pk_bound, eb);
  endtask

  task automatic do_op(logic [1:0] k, int d, int s);
    @(negedge clk);
    op_valid = 1; op_kind = k; op_dst = IW'(d); op_src = IW'(s);
    @(negedge clk);
    op_valid = 0;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    #150000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 busy", {31'd0, busy}, 0);
    check("R1 fault", {31'd0, fault}, 0);
    check("R1 mem_req", {31'd0, mem_req}, 0);
    for (int t = 0; t < N; t++) peek(t, "R1", 0, 0, 0);

    // R2 setup
    setreg(0, 0, 32'h100); setreg(0, 1, 5); setreg(0, 2, 10);
    setreg(1, 0, 32'h200); setreg(1, 1, 3); setreg(1, 2, 3);
    setreg(2, 0, 32'h300); setreg(2, 1, 8); setreg(2, 2, 7);
    setreg(3, 0, 32'h400); setreg(3, 3, 32'hDEAD);
    peek(0, "R2", 32'h100, 5, 10);
    peek(2, "R2", 32'h300, 8, 7);
    peek(3, "R2 sel3 ignored", 32'h400, 0, 0);

    // R3 load
    exp_req(32'h105, 0, 0, "R3 load");
    do_op(2'd0, 3, 0);
    peek(3, "R3 load result", mval(32'h105), 0, 0);

    // R5 equal index allowed
    exp_req(32'h203, 0, 0, "R5 equal");
    do_op(2'd0, 2, 1);
    peek(2, "R5 equal result", mval(32'h203), 8, 7);

    // R6 load fault on src
    exp_fault(2, "R6 load");
    do_op(2'd0, 3, 2);
    peek(3, "R6 load unchanged", mval(32'h105), 0, 0);
    check("R6 busy low", {31'd0, busy}, 0);

    // R4 store
    exp_req(32'h105, 1, 32'h200, "R4 store");
    do_op(2'd1, 0, 1);
    peek(0, "R4 store no change", 32'h100, 5, 10);

    // R6 store fault on dst
    exp_fault(2, "R6 store");
    do_op(2'd1, 2, 0);

    // R7 reference load
    exp_req(32'h105, 0, 0, "R7 ref lo");
    exp_req(32'h106, 0, 0, "R7 ref hi");
    @(negedge clk);
    op_valid = 1; op_kind = 2'd2; op_dst = 1; op_src = 0;
    @(negedge clk);
    op_valid = 0;
    repeat (3) @(negedge clk);
    check("R7 busy between", {31'd0, busy}, 1);
    repeat (6) @(negedge clk);
    check("R7 busy end", {31'd0, busy}, 0);
    peek(1, "R7 ref result", mval(32'h105), 3, mval(32'h106));

    // R8 op during busy ignored
    exp_req(mval(32'h105) + 3, 0, 0, "R8 load");
    @(negedge clk);
    op_valid = 1; op_kind = 2'd0; op_dst = 3; op_src = 1;
    @(negedge clk);
    op_kind = 2'd1; op_dst = 0; op_src = 0;
    @(negedge clk);
    op_valid = 0;
    repeat (8) @(negedge clk);
    peek(3, "R8 load result", mval(mval(32'h105) + 3), 0, 0);

    // R8 reserved kind ignored
    do_op(2'd3, 0, 0);
    peek(0, "R8 reserved", 32'h100, 5, 10);

    // R5 unsigned compare
    setreg(0, 1, 32'hFFFF_FFFF); setreg(0, 2, 32'h7FFF_FFFF);
    exp_fault(0, "R5 unsigned");
    do_op(2'd2, 3, 0);

    check("R9 scoreboard drained", q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule